// File: doc/BRIEF.md
# Aging Priority Task Selector

This block chooses which of a fixed set of task slots should run next. Each slot stores a static priority that is written when the task is created, a dynamic priority counter, and a ready flag. A task's effective priority is the sum of its static and dynamic parts. On a selection request the block grants the ready task with the largest effective priority and clears that task's dynamic part.

A periodic aging tick raises the dynamic part of every ready task that is not being granted on that edge. A task that keeps waiting therefore climbs until it overtakes tasks with higher static priority. This provides fairness without starvation. Tasks that are not ready neither age nor win.

Control is a two-state machine. In `ST_IDLE` the block waits. The transition `T_START` (taken on `sel_req`) moves it to `ST_PICK`. In `ST_PICK` the winner is resolved, the grant outputs are registered and the winner's dynamic part is cleared. The transition `T_DONE` then returns it unconditionally to `ST_IDLE`. The grant outputs hold their value until the next pick.

Top module: `aging_task_selector`

## Requirements
- R1: After reset, `grant_valid` is 0, `grant_idx` is 0, and every slot is not ready, with static and dynamic priority 0.
- R2: On a clock edge with `load_en` high, slot `load_idx` takes `load_prio` as its static priority, its dynamic priority becomes 0 and it becomes not ready. This overrides every other event on that slot in the same cycle. The static priority changes at no other time.
- R3: `rdy_set_en` makes slot `rdy_set_idx` ready and `rdy_clr_en` makes slot `rdy_clr_idx` not ready. When both name the same slot in the same cycle, the clear wins.
- R4: `sel_req` seen in `ST_IDLE` takes `T_START` to `ST_PICK` for exactly one cycle, then `T_DONE` returns to `ST_IDLE`. The grant outputs change only at the edge that leaves `ST_PICK`, so they are visible after the second rising edge following the request, and they hold until the next pick. `sel_req` is ignored while in `ST_PICK`.
- R5: The granted slot is a ready slot whose effective priority (static plus dynamic, computed one bit wider so that it never overflows) is the largest among ready slots.
- R6: Among ready slots that share the largest effective priority, the lowest index is granted.
- R7: If no slot is ready during `ST_PICK`, then `grant_valid` becomes 0 and `grant_idx` becomes 0.
- R8: On the edge that leaves `ST_PICK` with a valid winner, the winner's dynamic priority becomes 0, unless that slot is being loaded on the same edge.
- R9: On a clock edge with `age_tick` high, every ready slot other than the one being granted on that edge increments its dynamic priority by one. Slots that are not ready keep their dynamic priority.
- R10: The dynamic priority saturates at 2^DPRIO_W-1 and never wraps to a smaller value through aging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Create a task in slot `load_idx` |
| load_idx | input | IDX_W | Slot written by a load |
| load_prio | input | SPRIO_W | Static priority written by a load |
| rdy_set_en | input | 1 | Mark slot `rdy_set_idx` ready |
| rdy_set_idx | input | IDX_W | Slot to mark ready |
| rdy_clr_en | input | 1 | Mark slot `rdy_clr_idx` not ready |
| rdy_clr_idx | input | IDX_W | Slot to mark not ready |
| age_tick | input | 1 | Periodic aging event |
| sel_req | input | 1 | Request a selection |
| grant_valid | output | 1 | Last pick found a ready slot |
| grant_idx | output | IDX_W | Slot granted by the last pick (0 when none) |

## Verification
The assertions check several properties on every cycle: the one-cycle stay in `ST_PICK` and the start on a request; that the grant outputs hold outside a pick; that a pick with no ready slot deasserts `grant_valid`; and that a valid winner is ready. Inside each slot they check the following: the static priority is stable except on a load, a load's effect, the clear of the winner, single steps of aging, no aging while not ready, and saturation at the top value. Only the bench's scenarios can show that the winner is really the maximum over all slots with the lowest-index tie rule. The same holds for how aging over many ticks lets low static priorities overtake high ones, and for how a tick that coincides with a pick spares the winner. These need the whole set of slots and a history of events, so the bench checks them against a reference model through the grant outputs.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

    // Controller states: wait for a request, or resolve one pick.
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_PICK = 1'b1
    } sel_state_e;

    function automatic int unsigned wider_of(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/tsel_slot.sv
module tsel_slot #(
    parameter int unsigned SPRIO_W = 4,
    parameter int unsigned DPRIO_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_hit,
    input  logic [SPRIO_W-1:0] ld_prio,
    input  logic               set_hit,
    input  logic               clr_hit,
    input  logic               age_tick,
    input  logic               grant_hit,
    output logic               rdy,
    output logic [SPRIO_W-1:0] sprio,
    output logic [DPRIO_W-1:0] dprio
);

    localparam logic [DPRIO_W-1:0] DMAX = '1;

    logic               rdy_q;
    logic [SPRIO_W-1:0] sprio_q;
    logic [DPRIO_W-1:0] dprio_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_q   <= 1'b0;
            sprio_q <= '0;
            dprio_q <= '0;
        end else if (ld_hit) begin
            // creation overrides any other event on this slot
            rdy_q   <= 1'b0;
            sprio_q <= ld_prio;
            dprio_q <= '0;
        end else begin
            if (clr_hit) begin
                rdy_q <= 1'b0;
            end else if (set_hit) begin
                rdy_q <= 1'b1;
            end
            if (grant_hit) begin
                dprio_q <= '0;
            end else if (age_tick && rdy_q && (dprio_q != DMAX)) begin
                dprio_q <= dprio_q + 1'b1;
            end
        end
    end

    assign rdy   = rdy_q;
    assign sprio = sprio_q;
    assign dprio = dprio_q;

    // R2: static part changes only through a load
    a_r2_static_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_hit |=> $stable(sprio_q));

    // R2: a load writes static, clears dynamic and readiness
    a_r2_load_effect: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hit |=> (dprio_q == '0) && !rdy_q && (sprio_q == $past(ld_prio)));

    // R8: the granted slot restarts aging from zero
    a_r8_grant_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_hit && !ld_hit) |=> (dprio_q == '0));

    // R9: a waiting ready slot moves up by exactly one per tick
    a_r9_age_step: assert property (@(posedge clk) disable iff (!rst_n)
        (age_tick && rdy_q && !ld_hit && !grant_hit && (dprio_q != DMAX))
        |=> (dprio_q == $past(dprio_q) + 1'b1));

    // R9: slots that are not ready keep their dynamic part
    a_r9_idle_no_age: assert property (@(posedge clk) disable iff (!rst_n)
        (!rdy_q && !ld_hit) |=> $stable(dprio_q));

    // R9: a not-ready slot is never granted
    a_r9_no_grant_idle: assert property (@(posedge clk) disable iff (!rst_n)
        grant_hit |-> rdy_q);

    // R10: the counter stays at its top value under aging
    a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        ((dprio_q == DMAX) && !ld_hit && !grant_hit) |=> (dprio_q == DMAX));

endmodule

// File: rtl/tsel_argmax.sv
module tsel_argmax #(
    parameter int unsigned NUM_TASKS = 8,
    parameter int unsigned EFF_W     = 5,
    parameter int unsigned IDX_W     = 3
) (
    input  logic [NUM_TASKS-1:0] rdy_vec,
    input  logic [EFF_W-1:0]     eff [NUM_TASKS],
    output logic                 win_valid,
    output logic [IDX_W-1:0]     win_idx
);

    logic [EFF_W-1:0] best;

    // Linear scan: strict greater-than keeps the lowest index on ties.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        best      = '0;
        for (int i = 0; i < int'(NUM_TASKS); i++) begin
            if (rdy_vec[i] && (!win_valid || (eff[i] > best))) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
                best      = eff[i];
            end
        end
    end

endmodule

// File: rtl/aging_task_selector.sv
module aging_task_selector #(
    parameter int unsigned NUM_TASKS = 8,
    parameter int unsigned SPRIO_W   = 4,
    parameter int unsigned DPRIO_W   = 4,
    localparam int unsigned IDX_W    = (NUM_TASKS > 1) ? $clog2(NUM_TASKS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [IDX_W-1:0]   load_idx,
    input  logic [SPRIO_W-1:0] load_prio,
    input  logic               rdy_set_en,
    input  logic [IDX_W-1:0]   rdy_set_idx,
    input  logic               rdy_clr_en,
    input  logic [IDX_W-1:0]   rdy_clr_idx,
    input  logic               age_tick,
    input  logic               sel_req,
    output logic               grant_valid,
    output logic [IDX_W-1:0]   grant_idx
);

    import tsel_pkg::*;

    localparam int unsigned EFF_W = wider_of(SPRIO_W, DPRIO_W) + 1;

    sel_state_e state_q, state_d;

    logic [NUM_TASKS-1:0] rdy_vec;
    logic [SPRIO_W-1:0]   sprio [NUM_TASKS];
    logic [DPRIO_W-1:0]   dprio [NUM_TASKS];
    logic [EFF_W-1:0]     eff   [NUM_TASKS];
    logic                 win_valid;
    logic [IDX_W-1:0]     win_idx;
    logic                 picking;
    logic                 grant_valid_q;
    logic [IDX_W-1:0]     grant_idx_q;

    assign picking = (state_q == ST_PICK);

    // One slot per task
    for (genvar i = 0; i < NUM_TASKS; i++) begin : g_slot
        logic ld_hit, set_hit, clr_hit, grant_hit;

        assign ld_hit    = load_en    && (load_idx    == IDX_W'(i));
        assign set_hit   = rdy_set_en && (rdy_set_idx == IDX_W'(i));
        assign clr_hit   = rdy_clr_en && (rdy_clr_idx == IDX_W'(i));
        assign grant_hit = picking && win_valid && (win_idx == IDX_W'(i));

        tsel_slot #(
            .SPRIO_W (SPRIO_W),
            .DPRIO_W (DPRIO_W)
        ) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .ld_hit    (ld_hit),
            .ld_prio   (load_prio),
            .set_hit   (set_hit),
            .clr_hit   (clr_hit),
            .age_tick  (age_tick),
            .grant_hit (grant_hit),
            .rdy       (rdy_vec[i]),
            .sprio     (sprio[i]),
            .dprio     (dprio[i])
        );

        assign eff[i] = EFF_W'(sprio[i]) + EFF_W'(dprio[i]);
    end

    tsel_argmax #(
        .NUM_TASKS (NUM_TASKS),
        .EFF_W     (EFF_W),
        .IDX_W     (IDX_W)
    ) u_argmax (
        .rdy_vec   (rdy_vec),
        .eff       (eff),
        .win_valid (win_valid),
        .win_idx   (win_idx)
    );

    // Next-state logic: T_START on a request, T_DONE after one pick cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (sel_req) state_d = ST_PICK;
            ST_PICK: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register: loaded only when leaving ST_PICK
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_valid_q <= 1'b0;
            grant_idx_q   <= '0;
        end else if (picking) begin
            grant_valid_q <= win_valid;
            grant_idx_q   <= win_valid ? win_idx : '0;
        end
    end

    assign grant_valid = grant_valid_q;
    assign grant_idx   = grant_idx_q;

    // R4: a request in idle starts a pick
    a_r4_start: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE) && sel_req) |=> (state_q == ST_PICK));

    // R4: the pick state lasts exactly one cycle
    a_r4_pick_once: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PICK) |=> (state_q == ST_IDLE));

    // R4: grant outputs hold outside a pick
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |=> ($stable(grant_valid) && $stable(grant_idx)));

    // R7: no ready slot means no valid grant
    a_r7_none_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_PICK) && (rdy_vec == '0)) |=> (!grant_valid && (grant_idx == '0)));

    // R5: a valid winner is a ready slot
    a_r5_winner_ready: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_PICK) && win_valid) |-> rdy_vec[win_idx]);

endmodule

// File: tb/sim_aging_task_selector.sv
module sim_aging_task_selector;

    localparam int N     = 8;
    localparam int SW    = 4;
    localparam int DW    = 4;
    localparam int IW    = 3;
    localparam int DMAXV = (1 << DW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_en = 1'b0;
    logic [IW-1:0] load_idx = '0;
    logic [SW-1:0] load_prio = '0;
    logic          rdy_set_en = 1'b0;
    logic [IW-1:0] rdy_set_idx = '0;
    logic          rdy_clr_en = 1'b0;
    logic [IW-1:0] rdy_clr_idx = '0;
    logic          age_tick = 1'b0;
    logic          sel_req = 1'b0;
    logic          grant_valid;
    logic [IW-1:0] grant_idx;

    always #2 clk = ~clk;   // 250 MHz

    aging_task_selector #(.NUM_TASKS(N), .SPRIO_W(SW), .DPRIO_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .load_en(load_en), .load_idx(load_idx), .load_prio(load_prio),
        .rdy_set_en(rdy_set_en), .rdy_set_idx(rdy_set_idx),
        .rdy_clr_en(rdy_clr_en), .rdy_clr_idx(rdy_clr_idx),
        .age_tick(age_tick), .sel_req(sel_req),
        .grant_valid(grant_valid), .grant_idx(grant_idx)
    );

    // Reference model of the slots
    int m_sp  [N];
    int m_dp  [N];
    bit m_rdy [N];

    typedef struct {
        int    due;
        bit    v;
        int    idx;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   cyc = 0;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 0;
    int   last_v = 0;
    int   last_idx = 0;

    task automatic chk(input string req, input int act, input int expv);
        n_checks++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
        end
    endtask

    // Monitor: compares each expected grant in the cycle it must appear
    always @(posedge clk) begin
        #1;
        cyc++;
        if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
            exp_t e;
            e = exp_q.pop_front();
            chk({e.tag, " valid"}, int'(grant_valid), int'(e.v));
            chk({e.tag, " idx"},   int'(grant_idx),   e.idx);
        end
    end

    function automatic void model_winner(output bit v, output int idx);
        int best;
        best = -1;
        idx  = 0;
        v    = 0;
        for (int i = 0; i < N; i++) begin
            if (m_rdy[i] && (m_sp[i] + m_dp[i] > best)) begin
                best = m_sp[i] + m_dp[i];
                idx  = i;
                v    = 1;
            end
        end
    endfunction

    function automatic void model_age(input int skip);
        for (int i = 0; i < N; i++) begin
            if (m_rdy[i] && i != skip && m_dp[i] < DMAXV) m_dp[i]++;
        end
    endfunction

    // Driver tasks: entered at a falling edge, return at a falling edge
    task automatic load_task(input int i, input int p);
        load_en = 1; load_idx = IW'(i); load_prio = SW'(p);
        @(negedge clk);
        load_en = 0;
        m_sp[i] = p; m_dp[i] = 0; m_rdy[i] = 0;
    endtask

    task automatic set_rdy(input int i);
        rdy_set_en = 1; rdy_set_idx = IW'(i);
        @(negedge clk);
        rdy_set_en = 0;
        m_rdy[i] = 1;
    endtask

    task automatic clr_rdy(input int i);
        rdy_clr_en = 1; rdy_clr_idx = IW'(i);
        @(negedge clk);
        rdy_clr_en = 0;
        m_rdy[i] = 0;
    endtask

    task automatic set_clr_same(input int i);
        rdy_set_en = 1; rdy_set_idx = IW'(i);
        rdy_clr_en = 1; rdy_clr_idx = IW'(i);
        @(negedge clk);
        rdy_set_en = 0; rdy_clr_en = 0;
        m_rdy[i] = 0;   // R3: clear wins
    endtask

    task automatic tick(input int n);
        for (int k = 0; k < n; k++) begin
            age_tick = 1;
            @(negedge clk);
            age_tick = 0;
            model_age(-1);
        end
    endtask

    // hold_req: keep sel_req high through the pick cycle (must be ignored)
    task automatic select(input string tag, input bit tick_in_pick, input bit hold_req);
        exp_t e;
        bit   v;
        int   idx;
        model_winner(v, idx);
        e.due = cyc + 2; e.v = v; e.idx = idx; e.tag = tag;
        exp_q.push_back(e);
        sel_req = 1;
        @(negedge clk);
        sel_req = hold_req;
        if (tick_in_pick) age_tick = 1;
        @(negedge clk);
        sel_req = 0;
        age_tick = 0;
        if (v) m_dp[idx] = 0;
        if (tick_in_pick) model_age(v ? idx : -1);
        last_v = v; last_idx = idx;
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            m_sp[i] = 0; m_dp[i] = 0; m_rdy[i] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state at the outputs and in the slots
        chk("R1 reset valid", int'(grant_valid), 0);
        chk("R1 reset idx", int'(grant_idx), 0);
        select("R1 no slot ready after reset", 0, 0);
        // R7: explicit empty pick
        select("R7 empty pick", 0, 0);

        // R2: create tasks; loaded tasks are not ready
        load_task(0, 3); load_task(1, 9); load_task(2, 5); load_task(3, 9);
        load_task(4, 1); load_task(5, 12); load_task(6, 0); load_task(7, 7);
        select("R2 loaded tasks not ready", 0, 0);

        set_rdy(0); set_rdy(1); set_rdy(2); set_rdy(3);
        select("R6 tie 1 vs 3 lowest index", 0, 0);
        select("R5 highest effective", 0, 0);

        // R4: outputs hold while other events happen
        tick(1);
        set_rdy(4);
        chk("R4 hold valid", int'(grant_valid), last_v);
        chk("R4 hold idx", int'(grant_idx), last_idx);

        // R9: aging lifts waiting tasks
        tick(4);
        select("R9 aged task overtakes", 0, 0);
        select("R8 winner restarts from zero", 0, 0);
        select("R9 fairness rotation", 0, 0);

        // R10: saturation with many ticks; slot 6 not ready must not age
        set_rdy(5);
        tick(20);
        set_rdy(6);
        select("R10 saturated counters", 0, 0);
        select("R10 saturated second", 0, 0);
        clr_rdy(0); clr_rdy(1); clr_rdy(2); clr_rdy(3); clr_rdy(4); clr_rdy(5);
        set_rdy(7);
        select("R9 not-ready slot did not age", 0, 0);

        // R3: set and clear on the same slot -> clear wins
        set_clr_same(7);
        select("R3 clear wins over set", 0, 0);
        clr_rdy(6);
        select("R3 clear removes slot", 0, 0);

        // R9: tick during the pick spares the winner
        set_rdy(0); set_rdy(2); set_rdy(4);
        tick(2);
        select("R9 tick in pick", 1, 0);
        select("R9 after tick in pick", 0, 0);

        // R4: request held during the pick gives exactly one pick
        select("R4 held request", 0, 1);
        @(negedge clk);
        select("R4 after held request", 0, 0);

        // R2: reload of a ready task drops readiness and dynamic part
        load_task(2, 15);
        select("R2 reload clears ready", 0, 0);
        set_rdy(2);
        select("R2 reloaded static used", 0, 0);

        // Mixed random traffic checked against the model
        for (int it = 0; it < 300; it++) begin
            int op;
            op = $urandom_range(0, 9);
            case (op)
                0: load_task($urandom_range(0, N-1), $urandom_range(0, (1<<SW)-1));
                1, 2: set_rdy($urandom_range(0, N-1));
                3: clr_rdy($urandom_range(0, N-1));
                4, 5: tick($urandom_range(1, 6));
                6: select("R5 random pick", 1, 0);
                default: select("R5 random pick", 0, 0);
            endcase
        end

        repeat (4) @(negedge clk);
        chk("R4 all expected grants seen", exp_q.size(), 0);
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule